// File: doc/BRIEF.md
# Composite Video Sample Timing Generator

This block produces the sample and line timing for a 525-line composite video stream clocked at four times the colour subcarrier frequency. On each enabled clock it advances a sample position inside the line. It also keeps a line number and a four-field sequence index, which holds the field and the colour frame. From these it derives an active-video flag and a horizontal-blanking flag, and a two-bit label that names the chrominance axis the current sample falls on.

A line of 910 samples holds 227.5 subcarrier cycles, so the subcarrier phase at the start of a line is opposite to its phase at the start of the line before. The block records this in a per-line phase bit. That bit offsets the axis label and is also presented as a burst-polarity flag, which downstream burst and blanking waveform generators use to pick between their two sets of sample values. Because the frame holds an odd number of lines, the phase comes back to its starting value only after two frames, which is the four-field colour sequence.

Top module: `cvid_timing_gen`

## Requirements
- R1: `sample_o` counts 0 to SAMPLES_PER_LINE-1 (default 910, so 0 to 909) on each clock with `en_i` high, and returns to 0 after the last sample.
- R2: On lines outside the two vertical blanking ranges (defaults 1 to 9 and 264 to 272), `active_o` is high for samples 0 to ACTIVE_SAMPLES-1 (default 767) and `hblank_o` is high for samples ACTIVE_SAMPLES to the last sample (768 to 909). On lines inside those ranges both flags are low. The two flags are never high together.
- R3: `line_o` runs from 1 to LINES_PER_FRAME (default 525). It advances by one when the sample count wraps, and after the last line it returns to 1.
- R4: `field_seq_o[0]` is 1 on lines at or above FIELD2_LINE (default 264) and 0 below them. `field_seq_o[1]` is the colour frame (0 = A, 1 = B) and toggles each time the line count wraps from the last line to line 1.
- R5: `axis_o` uses the encoding 0 = +I, 1 = +Q, 2 = -I, 3 = -Q. It advances by one, modulo 4, on every enabled clock, and this includes the step from the last sample of a line to sample 0 of the next.
- R6: `burst_neg_o` inverts on every line start and is 1 on line 1 of colour frame A. `axis_o` at sample 0 is +I when `burst_neg_o` is 0 and -I when it is 1.
- R7: At sample 0 of line 10, field 1, colour frame A, `axis_o` reads +I (0). This holds again after every complete four-field sequence.
- R8: While `en_i` is low, every output holds its value.
- R9: While `rst_ni` is low, the block sits at sample 0, line 1, `field_seq_o` 0, `burst_neg_o` 1 and `axis_o` -I (2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance one sample |
| sample_o | output | $clog2(SAMPLES_PER_LINE) | Sample index in the line |
| line_o | output | $clog2(LINES_PER_FRAME+1) | Line number, from 1 |
| field_seq_o | output | 2 | {colour frame, field} |
| active_o | output | 1 | Active video sample |
| hblank_o | output | 1 | Horizontal blanking sample |
| axis_o | output | 2 | Chroma axis label |
| burst_neg_o | output | 1 | Burst polarity of the current line (1 = 180 degrees) |

## Verification
The bench targets the flag edges at samples 767/768 and 909/0. A comparator that is off by one at either edge would shift a blanking region by one sample or cut one short. It also checks that the axis label carries on across the line wrap. A design that resets the axis at sample 0 would repeat or skip an axis there and turn the burst polarity the wrong way. A second, small instance runs through several whole frames, which checks the frame wrap, the colour-frame toggle and the return of +I on line 10 after four fields. Gaps in the enable exercise the hold behaviour; a counter that ignored the enable would drift from the expected position.

// File: rtl/cvid_pkg.sv
package cvid_pkg;
  typedef enum logic [1:0] {
    AX_POS_I = 2'd0,
    AX_POS_Q = 2'd1,
    AX_NEG_I = 2'd2,
    AX_NEG_Q = 2'd3
  } axis_e;
endpackage

// File: rtl/cvid_sample_ctr.sv
module cvid_sample_ctr #(
  parameter int SPL = 910,
  localparam int SW = $clog2(SPL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic [SW-1:0] sample_o,
  output logic          eol_o
);
  localparam logic [SW-1:0] LAST = SW'(SPL - 1);

  logic [SW-1:0] cnt_q;

  assign eol_o    = (cnt_q == LAST);
  assign sample_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (en_i)  cnt_q <= eol_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/cvid_line_ctr.sv
module cvid_line_ctr #(
  parameter int LINES = 525,
  parameter int F2_LINE = 264,
  localparam int LW = $clog2(LINES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [LW-1:0] line_o,
  output logic          field_o,
  output logic          cframe_o,
  output logic          line_inv_o
);
  localparam logic [LW-1:0] LAST_LINE = LW'(LINES);
  localparam logic [LW-1:0] F2_FIRST  = LW'(F2_LINE);

  logic [LW-1:0] line_q;
  logic          cframe_q;
  logic          inv_q;

  // line 1 of frame A starts in inverted phase so line 10 lands on +I
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q   <= LW'(1);
      cframe_q <= 1'b0;
      inv_q    <= 1'b1;
    end else if (adv_i) begin
      inv_q <= ~inv_q;
      if (line_q == LAST_LINE) begin
        line_q   <= LW'(1);
        cframe_q <= ~cframe_q;
      end else begin
        line_q <= line_q + 1'b1;
      end
    end
  end

  assign line_o     = line_q;
  assign field_o    = (line_q >= F2_FIRST);
  assign cframe_o   = cframe_q;
  assign line_inv_o = inv_q;
endmodule

// File: rtl/cvid_blank_dec.sv
module cvid_blank_dec #(
  parameter int SPL = 910,
  parameter int ACTIVE = 768,
  parameter int LINES = 525,
  parameter int VB1_FIRST = 1,
  parameter int VB1_LAST = 9,
  parameter int VB2_FIRST = 264,
  parameter int VB2_LAST = 272,
  localparam int SW = $clog2(SPL),
  localparam int LW = $clog2(LINES + 1)
) (
  input  logic [SW-1:0] sample_i,
  input  logic [LW-1:0] line_i,
  output logic          active_o,
  output logic          hblank_o
);
  localparam logic [SW-1:0] ACT_END = SW'(ACTIVE);
  localparam logic [LW-1:0] V1F = LW'(VB1_FIRST);
  localparam logic [LW-1:0] V1L = LW'(VB1_LAST);
  localparam logic [LW-1:0] V2F = LW'(VB2_FIRST);
  localparam logic [LW-1:0] V2L = LW'(VB2_LAST);

  logic in_vb;
  logic in_act;

  always_comb begin
    in_vb  = ((line_i >= V1F) && (line_i <= V1L)) ||
             ((line_i >= V2F) && (line_i <= V2L));
    in_act = (sample_i < ACT_END);
    active_o = in_act && !in_vb;
    hblank_o = !in_act && !in_vb;
  end
endmodule

// File: rtl/cvid_axis_gen.sv
module cvid_axis_gen
  import cvid_pkg::*;
(
  input  logic [1:0] phase_i,
  input  logic       line_inv_i,
  output axis_e      axis_o
);
  // a half-cycle line offset is two sample steps on the axis wheel
  assign axis_o = axis_e'(phase_i + {line_inv_i, 1'b0});
endmodule

// File: rtl/cvid_timing_gen.sv
module cvid_timing_gen
  import cvid_pkg::*;
#(
  parameter int SAMPLES_PER_LINE = 910,
  parameter int ACTIVE_SAMPLES = 768,
  parameter int LINES_PER_FRAME = 525,
  parameter int FIELD2_LINE = 264,
  parameter int VB1_FIRST = 1,
  parameter int VB1_LAST = 9,
  parameter int VB2_FIRST = 264,
  parameter int VB2_LAST = 272,
  localparam int SW = $clog2(SAMPLES_PER_LINE),
  localparam int LW = $clog2(LINES_PER_FRAME + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic [SW-1:0] sample_o,
  output logic [LW-1:0] line_o,
  output logic [1:0]    field_seq_o,
  output logic          active_o,
  output logic          hblank_o,
  output logic [1:0]    axis_o,
  output logic          burst_neg_o
);
  logic  eol;
  logic  field;
  logic  cframe;
  logic  line_inv;
  axis_e axis;

  cvid_sample_ctr #(.SPL(SAMPLES_PER_LINE)) u_sample (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .sample_o (sample_o),
    .eol_o    (eol)
  );

  cvid_line_ctr #(.LINES(LINES_PER_FRAME), .F2_LINE(FIELD2_LINE)) u_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (en_i && eol),
    .line_o     (line_o),
    .field_o    (field),
    .cframe_o   (cframe),
    .line_inv_o (line_inv)
  );

  cvid_blank_dec #(
    .SPL(SAMPLES_PER_LINE), .ACTIVE(ACTIVE_SAMPLES), .LINES(LINES_PER_FRAME),
    .VB1_FIRST(VB1_FIRST), .VB1_LAST(VB1_LAST),
    .VB2_FIRST(VB2_FIRST), .VB2_LAST(VB2_LAST)
  ) u_blank (
    .sample_i (sample_o),
    .line_i   (line_o),
    .active_o (active_o),
    .hblank_o (hblank_o)
  );

  cvid_axis_gen u_axis (
    .phase_i    (sample_o[1:0]),
    .line_inv_i (line_inv),
    .axis_o     (axis)
  );

  assign field_seq_o = {cframe, field};
  assign axis_o      = axis;
  assign burst_neg_o = line_inv;
endmodule

// File: rtl/cvid_timing_chk.sv
module cvid_timing_chk #(
  parameter int SPL = 910,
  parameter int LINES = 525,
  localparam int SW = $clog2(SPL),
  localparam int LW = $clog2(LINES + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic [SW-1:0] sample_o,
  input logic [LW-1:0] line_o,
  input logic          active_o,
  input logic          hblank_o,
  input logic [1:0]    axis_o,
  input logic          burst_neg_o
);
  localparam logic [SW-1:0] LAST  = SW'(SPL - 1);
  localparam logic [LW-1:0] LLAST = LW'(LINES);

  AST_SAMPLE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o <= LAST); // R1
  AST_SAMPLE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && sample_o == LAST |=> sample_o == '0); // R1
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(active_o && hblank_o)); // R2
  AST_LINE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && sample_o == LAST && line_o != LLAST |=> line_o == $past(line_o) + 1'b1); // R3
  AST_LINE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && sample_o == LAST && line_o == LLAST |=> line_o == LW'(1)); // R3
  AST_AXIS_CONT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> axis_o == $past(axis_o) + 2'd1); // R5
  AST_BURST_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && sample_o == LAST |=> burst_neg_o != $past(burst_neg_o)); // R6
  AST_LINE0_AXIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o == '0 |-> axis_o == {burst_neg_o, 1'b0}); // R6
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(sample_o) && $stable(line_o) && $stable(axis_o)); // R8
endmodule

bind cvid_timing_gen cvid_timing_chk #(.SPL(SAMPLES_PER_LINE), .LINES(LINES_PER_FRAME)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .sample_o    (sample_o),
  .line_o      (line_o),
  .active_o    (active_o),
  .hblank_o    (hblank_o),
  .axis_o      (axis_o),
  .burst_neg_o (burst_neg_o)
);

// File: tb/cvid_timing_gen_tb_top.sv
module cvid_timing_gen_tb_top;
  typedef struct {
    int sample;
    int line;
    int fs;
    int act;
    int hb;
    int axis;
    int bneg;
    bit hold;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;

  logic [9:0] b_sample, b_line;
  logic [1:0] b_fs, b_axis;
  logic       b_act, b_hb, b_bneg;
  logic [4:0] s_sample;
  logic [3:0] s_line;
  logic [1:0] s_fs, s_axis;
  logic       s_act, s_hb, s_bneg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t q_big[$];
  exp_t q_sm[$];

  always #2 clk_i = ~clk_i;

  cvid_timing_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .sample_o(b_sample), .line_o(b_line), .field_seq_o(b_fs),
    .active_o(b_act), .hblank_o(b_hb), .axis_o(b_axis), .burst_neg_o(b_bneg)
  );

  cvid_timing_gen #(
    .SAMPLES_PER_LINE(22), .ACTIVE_SAMPLES(12), .LINES_PER_FRAME(11),
    .FIELD2_LINE(7), .VB1_FIRST(1), .VB1_LAST(2), .VB2_FIRST(7), .VB2_LAST(8)
  ) dut_small_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .sample_o(s_sample), .line_o(s_line), .field_seq_o(s_fs),
    .active_o(s_act), .hblank_o(s_hb), .axis_o(s_axis), .burst_neg_o(s_bneg)
  );

  // Reference from the requirements: position from the count of enabled clocks
  function automatic exp_t model(int spl, int act, int ln, int f2, int v1f, int v1l,
                                 int v2f, int v2l, int adv, bit hold);
    exp_t e;
    int lidx;
    int vb;
    lidx     = adv / spl;
    e.sample = adv % spl;
    e.line   = 1 + (lidx % ln);
    e.fs     = (((lidx / ln) % 2) << 1) | ((e.line >= f2) ? 1 : 0);
    e.bneg   = (lidx + 1) % 2;
    e.axis   = ((e.sample % 4) + 2 * e.bneg) % 4;
    vb       = ((e.line >= v1f && e.line <= v1l) || (e.line >= v2f && e.line <= v2l)) ? 1 : 0;
    e.act    = (e.sample < act && vb == 0) ? 1 : 0;
    e.hb     = (e.sample >= act && vb == 0) ? 1 : 0;
    e.hold   = hold;
    return e;
  endfunction

  task automatic chk(string who, string req, string what, int got, int exp, bit hold);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s%s %s got=%0d exp=%0d", who, req, hold ? " (R8 hold)" : "",
               what, got, exp);
    end
  endtask

  task automatic cmp(string who, exp_t e, int s, int l, int fs, int a, int h, int ax, int b);
    chk(who, "R1", "sample", s, e.sample, e.hold);
    chk(who, "R3", "line", l, e.line, e.hold);
    chk(who, "R4", "field_seq", fs, e.fs, e.hold);
    chk(who, "R2", "active", a, e.act, e.hold);
    chk(who, "R2", "hblank", h, e.hb, e.hold);
    chk(who, "R5", "axis", ax, e.axis, e.hold);
    chk(who, "R6", "burst_neg", b, e.bneg, e.hold);
    // R7: line 10 of field 1, frame A starts on +I
    if (s == 0 && l == 10 && fs == 0) chk(who, "R7", "axis line10", ax, 0, e.hold);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // monitor: pops one expected item per clock, just after the edge
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (q_big.size() > 0) begin
        exp_t eb;
        exp_t es;
        eb = q_big.pop_front();
        es = q_sm.pop_front();
        cmp("big", eb, int'(b_sample), int'(b_line), int'(b_fs), int'(b_act), int'(b_hb),
            int'(b_axis), int'(b_bneg));
        cmp("small", es, int'(s_sample), int'(s_line), int'(s_fs), int'(s_act), int'(s_hb),
            int'(s_axis), int'(s_bneg));
      end
    end
  end

  // driver
  initial begin
    int adv;
    adv = 0;
    repeat (3) @(negedge clk_i);
    // R9: reset state on both instances
    cmp("big", model(910, 768, 525, 264, 1, 9, 264, 272, 0, 1'b0), int'(b_sample), int'(b_line),
        int'(b_fs), int'(b_act), int'(b_hb), int'(b_axis), int'(b_bneg));
    cmp("small", model(22, 12, 11, 7, 1, 2, 7, 8, 0, 1'b0), int'(s_sample), int'(s_line),
        int'(s_fs), int'(s_act), int'(s_hb), int'(s_axis), int'(s_bneg));
    chk("big", "R9", "axis reset", int'(b_axis), 2, 1'b0);
    chk("big", "R9", "burst reset", int'(b_bneg), 1, 1'b0);
    rst_ni = 1'b1;
    for (int c = 0; c < 9400; c++) begin
      bit en;
      @(negedge clk_i);
      // R8: scattered single gaps plus one longer gap
      en = !((c % 53) == 7 || (c >= 4000 && c < 4006));
      en_i = en;
      if (en) adv++;
      q_big.push_back(model(910, 768, 525, 264, 1, 9, 264, 272, adv, !en));
      q_sm.push_back(model(22, 12, 11, 7, 1, 2, 7, 8, adv, !en));
    end
    @(negedge clk_i);
    en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule